// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects eleven interrupt requests plus the reset event. Each cycle it picks the most urgent request that is currently allowed to run. It drives that request's program address and a one-cycle take strobe to the instruction sequencer. The strobe means the handler is entered in that cycle.

Each request is held pending in one of two ways. Edge-sensed requests are captured in a latch. Level-sensed requests follow their pin. Software shapes which requests get through using four controls: a mask register, a control word, a force/clear port and a global enable. The control word picks the sensing of three of the inputs and turns preemption on or off.

A counter tracks how many handler entries are stacked. It saturates at the stack depth and flags an overflow. A return strobe pops one entry and ends the most urgent handler in service.

Top module: `prio_vec_intc`

## Requirements
- R1: In the first cycle after reset is released, `take_o` is 1 and `vec_o` is 0. The counter (`depth_o`) stays 0 across that take. The global enable comes out of reset set, and mask and control come out cleared.
- R2: Request index j has priority over every index above j. Index 0 (power-down) jumps to 0x2C. Every other index j jumps to 4*j: IRQ2 j=1, IRQL1 j=2, IRQL0 j=3, serial-0 transmit j=4, serial-0 receive j=5, IRQE j=6, byte transfer j=7, serial-1 transmit or IRQ1 j=8, serial-1 receive or IRQ0 j=9, timer j=10.
- R3: A pending request j is considered only when mask bit j is 1. Index 0 is considered regardless of its mask bit.
- R4: In the cycle after a cycle with `mask_we_i` high, no request is taken.
- R5: An edge-sensed request is latched on a 0-to-1 change sampled at a clock edge. It is taken no earlier than the next cycle, and its latch clears when it is taken. A level-sensed request is pending only while its pin is high.
- R6: Control bit 0, bit 1 and bit 2 set index 1, index 8 and index 9 to edge sensing (1) or level sensing (0). Indices 2 and 3 are always level-sensed. All other indices are always edge-sensed. A held-high edge input is taken once.
- R7: A write with `frc_we_i` high sets the pending latches in `frc_set_i` and clears those in `frc_clr_i`. A forced request is serviced like a captured edge.
- R8: While the global enable is clear, no request is taken, including index 0. `gie_clr_i` clears the enable, and it takes precedence over `gie_set_i`, which sets it.
- R9: Control bit 3 turns preemption on. With it on, a request is taken only if it outranks every request in service. With it off, nothing is taken while any request is in service. `rti_i` ends the most urgent request in service.
- R10: Each take except the reset take adds one to `depth_o`, and each `rti_i` subtracts one down to 0. A take that arrives at full depth leaves the depth unchanged and sets `ovf_o`. `ovf_o` then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 11 | Request inputs, index j as in R2 |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 11 | New mask value |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 4 | Bits 2..0 select sensing, bit 3 turns preemption on |
| frc_we_i | input | 1 | Force/clear write strobe |
| frc_set_i | input | 11 | Latches to set |
| frc_clr_i | input | 11 | Latches to clear |
| gie_set_i | input | 1 | Global enable on |
| gie_clr_i | input | 1 | Global enable off |
| rti_i | input | 1 | Return from handler |
| take_o | output | 1 | Handler entry this cycle |
| vec_o | output | VEC_W | Handler address |
| depth_o | output | clog2(STACK_DEPTH+1) | Stack entries in use |
| ovf_o | output | 1 | Sticky stack overflow |

## Verification
The bench holds a level input high across a mask write and expects no take in the blocked cycle. A design that applied the new mask at once, or blocked for two cycles, would strobe at the wrong time. It raises power-down, IRQE and a level line together while the global enable is off, then expects only the two latched requests once the enable returns. A design that latched level lines, or let power-down past the enable, would return extra or early vectors. It holds an edge-configured input high and expects exactly one entry. It nests pending requests with lower-, equal- and higher-priority arrivals, and drives the stack past its depth. Its checks catch a retriggering edge, preemption by an equal priority, and a wrapping counter.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   localparam int unsigned NREQ = 11;
   typedef logic [NREQ-1:0] req_vec_t;

   // Fixed sensing per request index; the three configurable ones are separate
   localparam req_vec_t EDGE_FIXED  = 11'h4F1;
   localparam req_vec_t LEVEL_FIXED = 11'h00C;
   localparam req_vec_t SENSE_CFG   = 11'h302;
   localparam int unsigned CFG_SEL0 = 1;
   localparam int unsigned CFG_SEL1 = 8;
   localparam int unsigned CFG_SEL2 = 9;

   localparam int unsigned PD_IDX   = 0;
   localparam logic [5:0]  PD_VEC   = 6'h2C;
   localparam req_vec_t    NONMASK  = 11'h001;

   function automatic logic [5:0] vec_of(input int unsigned idx);
      return (idx == PD_IDX) ? PD_VEC : 6'(idx * 4);
   endfunction
endpackage

// File: rtl/ivc_capture.sv
module ivc_capture #(
   parameter int unsigned N = 11
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] edge_mode_i,
   input  logic [N-1:0] force_set_i,
   input  logic [N-1:0] force_clr_i,
   input  logic [N-1:0] ack_i,
   output logic [N-1:0] pend_o
);
   for (genvar g = 0; g < N; g++) begin : g_src
      logic prev_q, latch_q, rise;
      assign rise = edge_mode_i[g] & req_i[g] & ~prev_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
         end else begin
            prev_q  <= req_i[g];
            latch_q <= rise | force_set_i[g] | (latch_q & ~force_clr_i[g] & ~ack_i[g]);
         end
      end

      assign pend_o[g] = latch_q | (~edge_mode_i[g] & req_i[g]);

      AST_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (rise && !ack_i[g]) |=> pend_o[g]); // R5
      AST_ACK_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ack_i[g] |-> pend_o[g]); // R2
   end
endmodule

// File: rtl/ivc_select.sv
module ivc_select
   import ivc_pkg::*;
#(
   parameter int unsigned N     = 11,
   parameter int unsigned VEC_W = 14
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N-1:0]     pend_i,
   input  logic [N-1:0]     enable_i,
   input  logic [N-1:0]     allow_i,
   input  logic             gie_i,
   input  logic             blk_i,
   input  logic             rst_pend_i,
   output logic             take_o,
   output logic [N-1:0]     ack_o,
   output logic [VEC_W-1:0] vec_o
);
   logic [N-1:0] cand;
   logic [5:0]   vec_lo;

   assign cand   = pend_i & enable_i & allow_i & {N{gie_i & ~blk_i & ~rst_pend_i}};
   assign ack_o  = cand & (~cand + N'(1));
   assign take_o = rst_pend_i | (|cand);

   always_comb begin
      vec_lo = '0;
      for (int i = 0; i < N; i++)
         if (ack_o[i]) vec_lo = vec_of(i);
   end
   assign vec_o = {{(VEC_W-6){1'b0}}, vec_lo};

   AST_GIE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gie_i |-> !(|ack_o)); // R8
   AST_BLOCK_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blk_i |-> !(|ack_o)); // R4
   AST_MASK_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(ack_o & ~enable_i)) == 1'b0); // R3
endmodule

// File: rtl/ivc_stack.sv
module ivc_stack #(
   parameter int unsigned N     = 11,
   parameter int unsigned DEPTH = 12,
   localparam int unsigned DW   = $clog2(DEPTH + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [N-1:0]  ack_i,
   input  logic          pop_i,
   output logic [N-1:0]  isr_o,
   output logic [DW-1:0] depth_o,
   output logic          ovf_o
);
   logic [N-1:0] isr_q, top;
   logic         push;

   assign push  = |ack_i;
   assign top   = isr_q & (~isr_q + N'(1));
   assign isr_o = isr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         isr_q   <= '0;
         depth_o <= '0;
         ovf_o   <= 1'b0;
      end else begin
         isr_q <= (isr_q & ~(pop_i ? top : '0)) | ack_i;
         if (push && !pop_i) begin
            if (depth_o == DW'(DEPTH)) ovf_o <= 1'b1;
            else                       depth_o <= depth_o + DW'(1);
         end else if (pop_i && !push && depth_o != '0) begin
            depth_o <= depth_o - DW'(1);
         end
      end
   end

   AST_DEPTH_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      depth_o <= DW'(DEPTH)); // R10
   AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |=> ovf_o); // R10
   AST_FULL_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push && !pop_i && depth_o == DW'(DEPTH)) |=> (ovf_o && $stable(depth_o))); // R10
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
   import ivc_pkg::*;
#(
   parameter int unsigned VEC_W       = 14,
   parameter int unsigned STACK_DEPTH = 12,
   localparam int unsigned DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NREQ-1:0]    req_i,
   input  logic               mask_we_i,
   input  logic [NREQ-1:0]    mask_wdata_i,
   input  logic               ctl_we_i,
   input  logic [3:0]         ctl_wdata_i,
   input  logic               frc_we_i,
   input  logic [NREQ-1:0]    frc_set_i,
   input  logic [NREQ-1:0]    frc_clr_i,
   input  logic               gie_set_i,
   input  logic               gie_clr_i,
   input  logic               rti_i,
   output logic               take_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic [DEPTH_W-1:0] depth_o,
   output logic               ovf_o
);
   if (VEC_W < 7) begin : g_bad_vec
      $error("VEC_W must hold the vector table");
   end
   if (STACK_DEPTH < 1) begin : g_bad_depth
      $error("STACK_DEPTH must be at least one");
   end
   if ((EDGE_FIXED | LEVEL_FIXED | SENSE_CFG) != '1 ||
       (EDGE_FIXED & LEVEL_FIXED) != '0 || (EDGE_FIXED & SENSE_CFG) != '0 ||
       (LEVEL_FIXED & SENSE_CFG) != '0) begin : g_bad_sense
      $error("sensing classes must partition the requests");
   end

   logic [NREQ-1:0] mask_q, edge_mode, pend, ack, isr, allow, isr_top;
   logic [3:0]      ctl_q;
   logic            gie_q, blk_q, rst_pend_q, nest;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q     <= '0;
         ctl_q      <= '0;
         gie_q      <= 1'b1;
         blk_q      <= 1'b0;
         rst_pend_q <= 1'b1;
      end else begin
         if (mask_we_i) mask_q <= mask_wdata_i;
         if (ctl_we_i)  ctl_q  <= ctl_wdata_i;
         if (gie_clr_i)      gie_q <= 1'b0;
         else if (gie_set_i) gie_q <= 1'b1;
         blk_q      <= mask_we_i;
         rst_pend_q <= 1'b0;
      end
   end

   assign nest = ctl_q[3];

   always_comb begin
      edge_mode           = EDGE_FIXED;
      edge_mode[CFG_SEL0] = ctl_q[0];
      edge_mode[CFG_SEL1] = ctl_q[1];
      edge_mode[CFG_SEL2] = ctl_q[2];
   end

   assign isr_top = isr & (~isr + NREQ'(1));
   assign allow   = (isr == '0) ? '1 : (nest ? (isr_top - NREQ'(1)) : '0);

   ivc_capture #(.N(NREQ)) u_capture (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (req_i),
      .edge_mode_i (edge_mode),
      .force_set_i (frc_we_i ? frc_set_i : '0),
      .force_clr_i (frc_we_i ? frc_clr_i : '0),
      .ack_i       (ack),
      .pend_o      (pend)
   );

   ivc_select #(.N(NREQ), .VEC_W(VEC_W)) u_select (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pend_i     (pend),
      .enable_i   (mask_q | NONMASK),
      .allow_i    (allow),
      .gie_i      (gie_q),
      .blk_i      (blk_q),
      .rst_pend_i (rst_pend_q),
      .take_o     (take_o),
      .ack_o      (ack),
      .vec_o      (vec_o)
   );

   ivc_stack #(.N(NREQ), .DEPTH(STACK_DEPTH)) u_stack (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ack_i   (ack),
      .pop_i   (rti_i),
      .isr_o   (isr),
      .depth_o (depth_o),
      .ovf_o   (ovf_o)
   );

   AST_MASK_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(mask_we_i) |-> (!take_o || vec_o == '0)); // R4
   AST_NO_NEST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!nest && isr != '0) |-> !take_o); // R9
   AST_RESET_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && vec_o == '0) |=> $stable(depth_o)); // R1
   AST_PREEMPT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nest && (|ack)) |-> ((ack & ~allow) == '0)); // R9
endmodule

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] req = '0, mask_wdata = '0, frc_set = '0, frc_clr = '0;
   logic        mask_we = 0, ctl_we = 0, frc_we = 0, gie_set = 0, gie_clr = 0, rti = 0;
   logic [3:0]  ctl_wdata = '0;
   logic        take, ovf;
   logic [13:0] vec;
   logic [2:0]  depth;
   int n_chk = 0, n_err = 0;

   always #5 clk = ~clk;

   prio_vec_intc #(.VEC_W(14), .STACK_DEPTH(4)) dut (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req),
      .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
      .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
      .frc_we_i(frc_we), .frc_set_i(frc_set), .frc_clr_i(frc_clr),
      .gie_set_i(gie_set), .gie_clr_i(gie_clr), .rti_i(rti),
      .take_o(take), .vec_o(vec), .depth_o(depth), .ovf_o(ovf));

   task automatic check(input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      mask_we = 0; ctl_we = 0; frc_we = 0; gie_set = 0; gie_clr = 0; rti = 0;
      frc_set = '0; frc_clr = '0;
   endtask

   task automatic expect_take(input string rq, input int t, input int v);
      #1;
      check(rq, "take", int'(take), t);
      if (t != 0) check(rq, "vector", int'(vec), v);
   endtask

   task automatic t_reset();
      #1;
      check("R1", "depth in reset", int'(depth), 0);
      check("R10", "ovf in reset", int'(ovf), 0);
      @(negedge clk); rst_n = 1;
      expect_take("R1", 1, 0);
      step(); expect_take("R1", 0, 0);
      check("R1", "depth after reset take", int'(depth), 0);
   endtask

   task automatic t_powerdown();
      step(); req[0] = 1; expect_take("R5", 0, 0);
      step(); req[0] = 0; expect_take("R3", 1, 'h2C);
      step(); expect_take("R9", 0, 0);
      check("R10", "depth after take", int'(depth), 1);
      rti = 1;
      step(); #1 check("R10", "depth after rti", int'(depth), 0);
   endtask

   task automatic t_mask_block();
      step(); req[3] = 1; expect_take("R3", 0, 0);
      step(); mask_we = 1; mask_wdata = '1; expect_take("R3", 0, 0);
      step(); expect_take("R4", 0, 0);
      step(); expect_take("R4", 1, 'h0C);
      step(); req[3] = 0; rti = 1; expect_take("R9", 0, 0);
      step(); #1 check("R10", "depth", int'(depth), 0);
   endtask

   task automatic t_global();
      step(); gie_clr = 1; expect_take("R8", 0, 0);
      step(); req[0] = 1; req[3] = 1; req[6] = 1; expect_take("R8", 0, 0);
      step(); req = '0; gie_set = 1; expect_take("R8", 0, 0);
      step(); expect_take("R2", 1, 'h2C);
      step(); rti = 1; expect_take("R9", 0, 0);
      step(); expect_take("R5", 1, 'h18);
      step(); rti = 1; expect_take("R5", 0, 0);
      step(); expect_take("R5", 0, 0);
      check("R5", "depth", int'(depth), 0);
   endtask

   task automatic t_sense();
      step(); ctl_we = 1; ctl_wdata = 4'b0001; expect_take("R6", 0, 0);
      step(); req[1] = 1; expect_take("R6", 0, 0);
      step(); expect_take("R6", 1, 'h04);
      step(); rti = 1; expect_take("R6", 0, 0);
      step(); expect_take("R6", 0, 0);
      ctl_we = 1; ctl_wdata = 4'b0000;
      step(); expect_take("R6", 1, 'h04);
      step(); req[1] = 0; rti = 1; expect_take("R6", 0, 0);
      step(); #1 check("R6", "depth", int'(depth), 0);
   endtask

   task automatic t_force();
      step(); gie_clr = 1; #1;
      step(); frc_we = 1; frc_set = 11'h480; expect_take("R7", 0, 0);
      step(); frc_we = 1; frc_clr = 11'h080; expect_take("R7", 0, 0);
      step(); gie_set = 1; expect_take("R7", 0, 0);
      step(); expect_take("R7", 1, 'h28);
      step(); rti = 1; expect_take("R7", 0, 0);
      step(); expect_take("R7", 0, 0);
      check("R7", "depth", int'(depth), 0);
   endtask

   task automatic t_nest();
      step(); ctl_we = 1; ctl_wdata = 4'b1000; expect_take("R9", 0, 0);
      step(); frc_we = 1; frc_set = 11'h400; expect_take("R9", 0, 0);
      step(); expect_take("R9", 1, 'h28);
      step(); frc_we = 1; frc_set = 11'h080; expect_take("R9", 0, 0);
      check("R10", "depth one", int'(depth), 1);
      step(); expect_take("R9", 1, 'h1C);
      step(); frc_we = 1; frc_set = 11'h400; expect_take("R9", 0, 0);
      check("R10", "depth two", int'(depth), 2);
      step(); expect_take("R9", 0, 0);
      rti = 1;
      step(); expect_take("R9", 0, 0);
      check("R10", "depth after pop", int'(depth), 1);
      frc_we = 1; frc_set = 11'h200;
      step(); expect_take("R9", 1, 'h24);
      frc_we = 1; frc_set = 11'h040;
      step(); expect_take("R9", 1, 'h18);
      frc_we = 1; frc_set = 11'h004;
      step(); expect_take("R9", 1, 'h08);
      check("R10", "depth three", int'(depth), 3);
      frc_we = 1; frc_set = 11'h002;
      step(); expect_take("R9", 1, 'h04);
      check("R10", "depth full", int'(depth), 4);
      check("R10", "ovf before", int'(ovf), 0);
      step(); #1;
      check("R10", "depth saturated", int'(depth), 4);
      check("R10", "ovf set", int'(ovf), 1);
      rti = 1;
      step(); #1;
      check("R10", "depth after rti", int'(depth), 3);
      check("R10", "ovf sticky", int'(ovf), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_powerdown();
      t_mask_block();
      t_global();
      t_sense();
      t_force();
      t_nest();
      step();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule